// File: doc/BRIEF.md
# SDRAM refresh and self-refresh manager

This block keeps a two-rank SDRAM alive. A free-running interval timer marks each point at which one Auto Refresh is due. The block then raises a request to the command sequencer and holds it until a grant comes back. One clock after the grant it issues a refresh command that applies to every rank. It then keeps other traffic off the bus for the row cycle time by holding its ready output low. If a periodic request waits too long for its grant, the deadline counts as missed. The block then issues a second refresh straight after the first.

The block also drives the clock-enable line of each rank. A sleep request, accepted only while all banks are precharged, turns into a refresh command issued with clock-enable low, which puts both ranks into self-refresh. A wake pulse raises clock-enable again. The exit is registered on the second rising edge after clock-enable goes high. A full row cycle time follows, then one extra Auto Refresh, and only after that does ready return.

Top module: `sdram_refresh_mgr`

## Requirements
- R1: While reset is held, both clock-enables are high, ready is high, and the request and command outputs are low.
- R2: With grants given in the first request cycle, successive periodic refresh commands are exactly REF_INTERVAL clock cycles apart.
- R3: The request stays high in every cycle until a grant is accepted. The command pulse appears exactly one cycle after the cycle in which request and grant were both high, and never without such a grant.
- R4: After a refresh command, ready stays low and no further command is issued for TRC_CYCLES cycles. Ready returns exactly TRC_CYCLES cycles after the command when no further refresh is owed.
- R5: A periodic request granted within its first SLACK request cycles produces exactly one refresh command.
- R6: A periodic request granted in request cycle SLACK+1 or later counts as missed. A second request then follows, and with an immediate grant the second command comes exactly TRC_CYCLES+1 cycles after the first.
- R7: A sleep request raises the request output. A grant is ignored while banks_idle is low, and the request stays high. An accepted grant yields a command pulse in the same cycle in which both clock-enables go low.
- R8: In self-refresh both clock-enables stay low, ready stays low, and no request is raised, however many refresh intervals elapse.
- R9: Both clock-enables rise in the cycle after wake is sampled in self-refresh. The request for the post-exit refresh rises exactly TRC_CYCLES+2 cycles after clock-enable rises.
- R10: After self-refresh exit, ready stays low until TRC_CYCLES cycles after the post-exit refresh command.
- R11: A wake pulse outside self-refresh changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_req | output | 1 | Request for the command bus (periodic, extra or self-refresh entry) |
| ref_gnt | input | 1 | Grant from the command sequencer |
| ref_cmd | output | 1 | One-cycle refresh command to all ranks (self-refresh entry when CKE is low) |
| sleep_req | input | 1 | Request to enter self-refresh |
| wake | input | 1 | Request to leave self-refresh |
| banks_idle | input | 1 | All banks of all ranks are precharged |
| cke | output | RANKS | Clock enable, one bit per rank |
| ready | output | 1 | Other traffic may use the bus |

## Verification
The bench sets the grant delay to exactly SLACK request cycles and then to SLACK+1. A slack comparison off by one would issue the extra refresh one case too early or too late. It holds the grant high while banks are still open during a sleep request. A design that does not gate the grant on banks_idle would drop clock-enable over active rows. On wake it times the request edge to the exact cycle. Counting the exit from the first edge instead of the second, or skipping the row-cycle wait, moves that edge. It also checks that ready stays low until the post-exit refresh has completed its own row cycle.

// File: rtl/srm_pkg.sv
package srm_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_REQ,
        ST_HOLD,
        ST_SREQ,
        ST_SELF,
        ST_XWAIT,
        ST_XHOLD
    } srm_state_e;
endpackage

// File: rtl/srm_interval_timer.sv
module srm_interval_timer #(
    parameter int INTERVAL = 1040
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int IW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [IW-1:0] LOAD = IW'(INTERVAL - 1);

    logic [IW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = 1'b0;
        cnt_d = cnt_q;
        if (hold) begin
            cnt_d = LOAD;
        end else if (cnt_q == '0) begin
            cnt_d = LOAD;
            tick  = 1'b1;
        end else begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= LOAD;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/srm_pend_tracker.sv
module srm_pend_tracker #(
    parameter int SLACK = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clear,
    input  logic count_en,
    output logic pending,
    output logic late
);
    localparam int WW = $clog2(SLACK + 1);
    localparam logic [WW-1:0] LIMIT = WW'(SLACK);

    typedef struct packed {
        logic          pend;
        logic [WW-1:0] waited;
    } trk_t;

    trk_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.pend   = 1'b0;
            r_d.waited = '0;
        end else if (count_en && r_q.pend && (r_q.waited != LIMIT)) begin
            r_d.waited = r_q.waited + 1'b1;
        end
        if (tick) r_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pending = r_q.pend;
    assign late    = (r_q.waited >= LIMIT);
endmodule

// File: rtl/sdram_refresh_mgr.sv
module sdram_refresh_mgr
    import srm_pkg::*;
#(
    parameter int RANKS        = 2,
    parameter int REF_INTERVAL = 1040,
    parameter int SLACK        = 64,
    parameter int TRC_CYCLES   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             ref_req,
    input  logic             ref_gnt,
    output logic             ref_cmd,
    input  logic             sleep_req,
    input  logic             wake,
    input  logic             banks_idle,
    output logic [RANKS-1:0] cke,
    output logic             ready
);
    localparam int CW = (TRC_CYCLES > 2) ? $clog2(TRC_CYCLES) : 1;
    localparam logic [CW-1:0] TRC_LAST = CW'(TRC_CYCLES - 1);

    typedef struct packed {
        srm_state_e    state;
        logic [CW-1:0] cnt;
        logic          more;
        logic          cke;
        logic          cmd;
    } fsm_t;

    fsm_t r_d, r_q;

    logic tick, pending, late;
    logic pend_clr, wait_en, timer_hold;

    assign timer_hold = (r_q.state == ST_SELF) || (r_q.state == ST_XWAIT) ||
                        (r_q.state == ST_XHOLD);

    srm_interval_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (timer_hold),
        .tick  (tick)
    );

    srm_pend_tracker #(.SLACK(SLACK)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clear    (pend_clr),
        .count_en (wait_en),
        .pending  (pending),
        .late     (late)
    );

    always_comb begin
        r_d      = r_q;
        r_d.cmd  = 1'b0;
        pend_clr = 1'b0;
        wait_en  = 1'b0;
        unique case (r_q.state)
            ST_RUN: begin
                if (pending) begin
                    r_d.state = ST_REQ;
                    r_d.more  = 1'b0;
                end else if (sleep_req) begin
                    r_d.state = ST_SREQ;
                end
            end
            ST_REQ: begin
                if (ref_gnt) begin
                    r_d.cmd   = 1'b1;
                    r_d.state = ST_HOLD;
                    r_d.cnt   = TRC_LAST;
                    r_d.more  = pending && late;
                    pend_clr  = pending;
                end else begin
                    wait_en = pending;
                end
            end
            ST_HOLD: begin
                if (r_q.cnt == '0) begin
                    r_d.state = r_q.more ? ST_REQ : ST_RUN;
                    r_d.more  = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_SREQ: begin
                if (ref_gnt && banks_idle) begin
                    r_d.cmd   = 1'b1;
                    r_d.cke   = 1'b0;
                    r_d.state = ST_SELF;
                    pend_clr  = 1'b1;
                end
            end
            ST_SELF: begin
                if (wake) begin
                    r_d.cke   = 1'b1;
                    r_d.state = ST_XWAIT;
                    r_d.cnt   = CW'(1);
                end
            end
            ST_XWAIT: begin
                if (r_q.cnt == '0) begin
                    r_d.state = ST_XHOLD;
                    r_d.cnt   = TRC_LAST;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_XHOLD: begin
                if (r_q.cnt == '0) begin
                    r_d.state = ST_REQ;
                    r_d.more  = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_RUN;
            r_q.cnt   <= '0;
            r_q.more  <= 1'b0;
            r_q.cke   <= 1'b1;
            r_q.cmd   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ref_req = (r_q.state == ST_REQ) || (r_q.state == ST_SREQ);
    assign ref_cmd = r_q.cmd;
    assign ready   = (r_q.state == ST_RUN);

    for (genvar g = 0; g < RANKS; g++) begin : g_cke
        assign cke[g] = r_q.cke;
    end
endmodule

// File: rtl/srm_checker.sv
module srm_checker #(
    parameter int RANKS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_req,
    input logic             ref_gnt,
    input logic             ref_cmd,
    input logic             wake,
    input logic             banks_idle,
    input logic [RANKS-1:0] cke,
    input logic             ready
);
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_gnt) |=> ref_req);

    p_cmd_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |-> $past(ref_req && ref_gnt));

    p_quiet_after_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |=> (!ref_cmd && !ready));

    p_cke_fall_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke[0]) |-> ref_cmd);

    p_entry_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_cmd && (cke == '0)) |-> $past(banks_idle));

    p_ready_cke_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (&cke));

    p_cke_uniform_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cke == '0) || (&cke)));

    p_self_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cke == '0) |-> (!ref_req && !ready));

    p_cke_rise_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke[0]) |-> $past(wake));

    p_no_req_at_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke[0]) |=> (!ref_req && !ready));
endmodule

bind sdram_refresh_mgr srm_checker #(.RANKS(RANKS)) u_srm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_req    (ref_req),
    .ref_gnt    (ref_gnt),
    .ref_cmd    (ref_cmd),
    .wake       (wake),
    .banks_idle (banks_idle),
    .cke        (cke),
    .ready      (ready)
);

// File: tb/sdram_refresh_mgr_tb.sv
module sdram_refresh_mgr_tb;
    localparam int INTV = 40;
    localparam int SLK  = 4;
    localparam int TRC  = 5;

    logic       clk = 1'b0;
    logic       rst_n, ref_req, ref_gnt, ref_cmd, sleep_req, wake, banks_idle, ready;
    logic [1:0] cke;

    int cyc = 0;
    int n_tests = 0, n_fail = 0;
    int n_cmd = 0, last = -100, prev = -100;
    int gnt_delay = 1;
    int k = 0;

    typedef struct { int c; bit self; } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_refresh_mgr #(.RANKS(2), .REF_INTERVAL(INTV), .SLACK(SLK), .TRC_CYCLES(TRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_gnt(ref_gnt), .ref_cmd(ref_cmd),
        .sleep_req(sleep_req), .wake(wake), .banks_idle(banks_idle), .cke(cke), .ready(ready)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic at_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Driver side: grant responder, pushes the command it expects
    always @(negedge clk) begin
        if (!rst_n) begin
            k = 0;
            ref_gnt <= 1'b0;
        end else if (ref_req) begin
            k++;
            if (k >= gnt_delay) begin
                ref_gnt <= 1'b1;
                if (!(sleep_req && !banks_idle)) q.push_back('{cyc + 1, sleep_req});
            end else begin
                ref_gnt <= 1'b0;
            end
        end else begin
            k = 0;
            ref_gnt <= 1'b0;
        end
    end

    // Monitor: pops expected commands and compares
    always @(negedge clk) begin
        if (rst_n) begin
            if (ref_cmd) begin
                exp_t e;
                n_cmd++;
                prev = last;
                last = cyc;
                if (q.size() == 0) begin
                    check(1'b0, "R3 unexpected command", cyc, -1);
                end else begin
                    e = q.pop_front();
                    check(e.c == cyc, "R3 command cycle", cyc, e.c);
                    if (e.self) check(cke == 2'b00, "R7 cke at entry", int'(cke), 0);
                    else        check(cke == 2'b11, "R3 cke at refresh", int'(cke), 3);
                end
            end
            if (ready && n_cmd > 0 && (cyc - last) < TRC)
                check(1'b0, "R4 ready inside row cycle", cyc - last, TRC);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int c, a;
        bit bad;
        rst_n = 1'b0; sleep_req = 1'b0; wake = 1'b0; banks_idle = 1'b1;
        repeat (3) @(negedge clk);
        check(cke == 2'b11, "R1 cke in reset", int'(cke), 3);
        check(ready == 1'b1, "R1 ready in reset", int'(ready), 1);
        check(ref_req == 1'b0, "R1 req in reset", int'(ref_req), 0);
        check(ref_cmd == 1'b0, "R1 cmd in reset", int'(ref_cmd), 0);
        @(posedge clk); #1 rst_n = 1'b1;

        wait (n_cmd == 1);
        c = last;
        at_cyc(c + TRC - 1);
        check(ready == 1'b0, "R4 ready low before row cycle", int'(ready), 0);
        at_cyc(c + TRC);
        check(ready == 1'b1, "R4 ready after row cycle", int'(ready), 1);

        wait (n_cmd == 3);
        check(last - prev == INTV, "R2 refresh spacing", last - prev, INTV);

        gnt_delay = SLK;
        wait (n_cmd == 4);
        at_cyc(last + TRC + 4);
        check(n_cmd == 4, "R5 single refresh within slack", n_cmd, 4);

        gnt_delay = SLK + 1;
        wait (n_cmd == 5);
        gnt_delay = 1;
        c = last;
        wait (n_cmd == 6);
        check(last - c == TRC + 1, "R6 extra refresh spacing", last - c, TRC + 1);
        at_cyc(last + TRC);
        check(ready == 1'b1, "R6 ready after extra refresh", int'(ready), 1);

        @(posedge clk); #1 sleep_req = 1'b1; banks_idle = 1'b0;
        repeat (6) @(negedge clk);
        check(ref_req == 1'b1, "R7 request held while banks open", int'(ref_req), 1);
        check(n_cmd == 6, "R7 no entry while banks open", n_cmd, 6);
        check(cke == 2'b11, "R7 cke high while banks open", int'(cke), 3);
        @(posedge clk); #1 banks_idle = 1'b1;
        wait (n_cmd == 7);
        check(cke == 2'b00, "R7 cke low at entry", int'(cke), 0);
        @(posedge clk); #1 sleep_req = 1'b0;

        bad = 1'b0;
        for (int i = 0; i < 3 * INTV; i++) begin
            @(negedge clk);
            if (ref_req || ready || cke != 2'b00) bad = 1'b1;
        end
        check(!bad, "R8 quiet in self-refresh", int'(bad), 0);
        check(n_cmd == 7, "R8 no refresh in self-refresh", n_cmd, 7);

        @(posedge clk); #1 wake = 1'b1; a = cyc;
        @(posedge clk); #1 wake = 1'b0;
        at_cyc(a + 1);
        check(cke == 2'b11, "R9 cke rises after wake", int'(cke), 3);
        at_cyc(a + 2 + TRC);
        check(ref_req == 1'b0, "R9 no request before exit wait", int'(ref_req), 0);
        check(ready == 1'b0, "R10 ready low during exit", int'(ready), 0);
        at_cyc(a + 3 + TRC);
        check(ref_req == 1'b1, "R9 request after exit wait", int'(ref_req), 1);
        wait (n_cmd == 8);
        check(last == a + 4 + TRC, "R10 post-exit refresh cycle", last, a + 4 + TRC);
        at_cyc(last + TRC - 1);
        check(ready == 1'b0, "R10 ready low before post-exit row cycle", int'(ready), 0);
        at_cyc(last + TRC);
        check(ready == 1'b1, "R10 ready after post-exit refresh", int'(ready), 1);

        @(posedge clk); #1 wake = 1'b1;
        @(posedge clk); #1 wake = 1'b0;
        bad = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (cke != 2'b11 || !ready || ref_req) bad = 1'b1;
        end
        check(!bad, "R11 wake ignored when running", int'(bad), 0);
        check(q.size() == 0, "R3 all expected commands seen", q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule